// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two entries from page tables held in ordinary memory. A client offers one translation request at a time, tagged as a read or a write access. The walker slices the address into a top-level index, a second-level index and a byte offset within a 4 KB page. It fetches the top-level entry to locate the second-level table, fetches the page table entry (PTE), and judges the PTE's valid and permission bits. On success it sets the referenced flag (and the dirty flag for writes) in the PTE and returns the frame number joined to the untouched offset. Otherwise it returns a fault code.

The top-level table's location is a frame number loaded through a small configuration port before traffic starts. The memory side is a single request/response channel with any latency, and the walker keeps at most one memory access in flight. A PTE is written back only when one of its flags actually changes. The translation response is not raised until that write has been acknowledged. Filling in tables and servicing faults are left to software.

Top module: `pt_walker`

## Requirements
- R1: The virtual address is split as bits 31:24 (top-level index), 23:12 (second-level index) and 11:0 (offset). The top-level entry is read at base_frame·4096 + index·4. The PTE is read at second_frame·4096 + index·4, where second_frame is bits 31:12 of the top-level entry. A memory request holds its address, data and write flag stable until it is accepted.
- R2: On success the response carries fault code 0 and physical address {PTE[31:12], VA[11:0]}.
- R3: If bit 7 (valid) of the top-level entry is clear, the response carries fault code 1 after exactly one memory read, and no PTE is read.
- R4: If bit 7 (valid) of the PTE is clear, the response carries fault code 1 and physical address 0, and nothing is written to memory. Every faulting response reports physical address 0.
- R5: PTE bits 11:10 are the permission field. Bit 10 allows reads and bit 11 allows writes, and a write needs both bits. A denied access gets fault code 2 and causes no memory write. Fault code 3 never occurs.
- R6: On success PTE bit 8 (referenced) is set, and for a write PTE bit 9 (dirty) is also set. The updated PTE is written back to the address it was read from, with every other bit unchanged.
- R7: The write-back happens only when the updated PTE differs from the one read. Otherwise the walk makes exactly two reads and no write.
- R8: The response is raised only after any write-back has been acknowledged. While no memory request is pending, it holds its fault code and address stable until rsp_ready is seen.
- R9: req_ready is high only when the walker is idle. busy rises in the cycle after a request is accepted and falls in the cycle after the response handshake.
- R10: A configuration write loads the top-level base frame, and every later walk uses the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the top-level base frame |
| cfg_base | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 page fault, 2 permission fault |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory access requested |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the 32-bit entry |
| mem_req_wdata | output | 32 | Updated PTE for a write-back |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 32 | Entry read from memory |

## Verification
The hardest case to reach from the ports is a PTE write-back held up by a slow memory while the client is already waiting for its answer. It only happens when a valid, permitted PTE is missing a flag, and only if the memory stalls both the request and the acknowledge. The bench fills small tables with random flags, permissions and valid bits, and aims addresses partly at unmapped indices. The memory model applies random request back-pressure and random response latency. A directed sequence repeats a read on the same page, then a write, then a denied write, so that the change-only write-back rule is hit on each side.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int MIDX_W = 8,
  parameter int SIDX_W = 12,
  parameter int OFF_W  = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [MIDX_W+SIDX_W-1:0]         cfg_base,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [MIDX_W+SIDX_W+OFF_W-1:0]   req_vaddr,
  input  logic                             req_write,
  output logic                             rsp_valid,
  input  logic                             rsp_ready,
  output logic [MIDX_W+SIDX_W+OFF_W-1:0]   rsp_paddr,
  output logic [1:0]                       rsp_fault,
  output logic                             busy,
  output logic                             mem_req_valid,
  input  logic                             mem_req_ready,
  output logic                             mem_req_write,
  output logic [MIDX_W+SIDX_W+OFF_W-1:0]   mem_req_addr,
  output logic [MIDX_W+SIDX_W+OFF_W-1:0]   mem_req_wdata,
  input  logic                             mem_rsp_valid,
  input  logic [MIDX_W+SIDX_W+OFF_W-1:0]   mem_rsp_rdata
);
  localparam int VA_W    = MIDX_W + SIDX_W + OFF_W;
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int B_WR    = OFF_W - 1;
  localparam int B_RD    = OFF_W - 2;
  localparam int B_DIRTY = OFF_W - 3;
  localparam int B_REF   = OFF_W - 4;
  localparam int B_VAL   = OFF_W - 5;
  localparam logic [1:0] F_OK = 2'd0, F_PAGE = 2'd1, F_PERM = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_MREQ, S_MWAIT, S_PREQ, S_PWAIT, S_WREQ, S_WWAIT, S_RESP
  } state_t;

  state_t               state;
  logic [FRAME_W-1:0]   base_q;
  logic [FRAME_W-1:0]   sec_q;
  logic [VA_W-1:0]      va_q;
  logic                 wr_q;
  logic [VA_W-1:0]      pte_q;
  logic [VA_W-1:0]      pa_q;
  logic [1:0]           fault_q;
  logic                 busy_q;

  wire [MIDX_W-1:0] midx = va_q[VA_W-1 -: MIDX_W];
  wire [SIDX_W-1:0] sidx = va_q[OFF_W +: SIDX_W];

  wire [VA_W-1:0] top_addr = {base_q, {OFF_W{1'b0}}}
                           + {{(VA_W-MIDX_W-2){1'b0}}, midx, 2'b00};
  wire [VA_W-1:0] pte_addr = {sec_q, {OFF_W{1'b0}}}
                           + {{(VA_W-SIDX_W-2){1'b0}}, sidx, 2'b00};

  wire [VA_W-1:0] pte_upd = pte_q | (VA_W'(1) << B_REF)
                          | (wr_q ? (VA_W'(1) << B_DIRTY) : '0);

  wire rd_ok   = mem_rsp_rdata[B_RD];
  wire wr_ok   = mem_rsp_rdata[B_RD] & mem_rsp_rdata[B_WR];
  wire perm_ok = wr_q ? wr_ok : rd_ok;
  wire need_wb = ~mem_rsp_rdata[B_REF] | (wr_q & ~mem_rsp_rdata[B_DIRTY]);

  assign req_ready     = (state == S_IDLE);
  assign busy          = busy_q;
  assign rsp_valid     = (state == S_RESP);
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = (state == S_MREQ) || (state == S_PREQ) || (state == S_WREQ);
  assign mem_req_write = (state == S_WREQ);
  assign mem_req_addr  = (state == S_MREQ) ? top_addr : pte_addr;
  assign mem_req_wdata = pte_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sec_q   <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      pte_q   <= '0;
      pa_q    <= '0;
      fault_q <= F_OK;
      busy_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          busy_q <= 1'b1;
          state  <= S_MREQ;
        end
        S_MREQ: if (mem_req_ready) state <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_rdata[B_VAL]) begin
            fault_q <= F_PAGE;
            pa_q    <= '0;
            state   <= S_RESP;
          end else begin
            sec_q <= mem_rsp_rdata[VA_W-1 -: FRAME_W];
            state <= S_PREQ;
          end
        end
        S_PREQ: if (mem_req_ready) state <= S_PWAIT;
        S_PWAIT: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_rdata;
          if (!mem_rsp_rdata[B_VAL]) begin
            fault_q <= F_PAGE;
            pa_q    <= '0;
            state   <= S_RESP;
          end else if (!perm_ok) begin
            fault_q <= F_PERM;
            pa_q    <= '0;
            state   <= S_RESP;
          end else begin
            fault_q <= F_OK;
            pa_q    <= {mem_rsp_rdata[VA_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
            state   <= need_wb ? S_WREQ : S_RESP;
          end
        end
        S_WREQ: if (mem_req_ready) state <= S_WWAIT;
        S_WWAIT: if (mem_rsp_valid) state <= S_RESP;
        S_RESP: if (rsp_ready) begin
          busy_q <= 1'b0;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            busy,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [VA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [VA_W-1:0] mem_req_addr,
  input logic [VA_W-1:0] mem_req_wdata
);
  p_req_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  p_fault_zero_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0);

  p_fault_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3);

  p_wb_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[OFF_W-4] && mem_req_wdata[OFF_W-5]);

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  p_rsp_no_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid);

  p_idle_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  p_rsp_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !busy && req_ready);
endmodule

bind pt_walker pt_walker_chk #(.VA_W(MIDX_W + SIDX_W + OFF_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [19:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  always #5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  // Memory model: all storage writes happen here
  logic [31:0] mem [logic [31:0]];
  logic        bd_we = 1'b0;
  logic [31:0] bd_addr = '0, bd_data = '0;
  logic        cnt_clr = 1'b0;
  int          n_rd, n_wr;
  logic [31:0] rd_a0, rd_a1, wr_a;
  logic        pend, pw, rdy_q;
  logic [31:0] pa, pd;
  int          lat;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  assign mem_req_ready = rdy_q && !pend;

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr] = bd_data;
    if (cnt_clr) begin n_rd = 0; n_wr = 0; end
    rdy_q <= ($urandom % 4) != 0;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        pend = 1'b0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= pw ? 32'h0 : rd(pa);
        if (pw) mem[pa] = pd;
      end else lat = lat - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      pend = 1'b1; pa = mem_req_addr; pw = mem_req_write; pd = mem_req_wdata;
      lat = $urandom % 4;
      if (pw) begin n_wr = n_wr + 1; wr_a = pa; end
      else begin
        if (n_rd == 0) rd_a0 = pa; else rd_a1 = pa;
        n_rd = n_rd + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  logic done = 1'b0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(posedge clk); #1 bd_we = 1'b0;
  endtask

  task automatic set_base(input logic [19:0] b);
    cfg_we = 1'b1; cfg_base = b;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  logic [19:0] cur_base;

  task automatic txn(input logic [31:0] va, input bit wr);
    logic [31:0] ta, te, paddr2, pte, npte, epa;
    logic [1:0]  ef;
    int er, ew;
    ta = {cur_base, 12'h0} + {22'h0, va[31:24], 2'b00};
    te = rd(ta);
    paddr2 = {te[31:12], 12'h0} + {18'h0, va[23:12], 2'b00};
    pte = 32'h0; npte = 32'h0; epa = 32'h0; ew = 0;
    if (!te[7]) begin ef = 2'd1; er = 1; end
    else begin
      er = 2; pte = rd(paddr2);
      if (!pte[7]) ef = 2'd1;
      else if (!(wr ? (pte[11] & pte[10]) : pte[10])) ef = 2'd2;
      else begin
        ef = 2'd0; epa = {pte[31:12], va[11:0]};
        npte = pte | 32'h100 | (wr ? 32'h200 : 32'h0);
        ew = (npte != pte) ? 1 : 0;
      end
    end
    cnt_clr = 1'b1; @(posedge clk); #1 cnt_clr = 1'b0;
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1 req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", {31'h0, busy}, 32'h1);
    while (rsp_valid !== 1'b1) @(negedge clk);
    chk(rsp_fault === ef, "R2/R3/R4/R5 fault code", {30'h0, rsp_fault}, {30'h0, ef});
    chk(rsp_paddr === epa, "R2 physical address", rsp_paddr, epa);
    chk(n_rd == er, "R3 read count", n_rd, er);
    chk(rd_a0 === ta, "R1 top entry address", rd_a0, ta);
    if (er == 2) chk(rd_a1 === paddr2, "R1 pte address", rd_a1, paddr2);
    chk(n_wr == ew, "R7 write-back count before response R8", n_wr, ew);
    if (ew == 1) begin
      chk(wr_a === paddr2, "R6 write-back address", wr_a, paddr2);
      chk(rd(paddr2) === npte, "R6 updated pte", rd(paddr2), npte);
    end else if (er == 2) begin
      chk(rd(paddr2) === pte, "R4/R5/R7 pte unchanged", rd(paddr2), pte);
    end
    for (int i = 0; i < int'($urandom % 3); i++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_paddr === epa && rsp_fault === ef,
          "R8 response held", rsp_paddr, epa);
    end
    rsp_ready = 1'b1; @(posedge clk); #1 rsp_ready = 1'b0;
    chk(busy === 1'b0 && req_ready === 1'b1, "R9 release after handshake",
        {30'h0, busy, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pend = 1'b0; rdy_q = 1'b0; n_rd = 0; n_wr = 0; lat = 0;
    rd_a0 = '0; rd_a1 = '0; wr_a = '0; pa = '0; pd = '0; pw = 1'b0;
    mem_rsp_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
        "reset state R9", {28'h0, req_ready, busy, rsp_valid, mem_req_valid}, 32'h8);

    // Directed: VA 0x12345678 mapped to frame 0x01000, read-only
    cur_base = 20'h00100; set_base(cur_base);
    poke(32'h00100000 + 32'h12 * 4, 32'h00300080);
    poke(32'h00300000 + 32'h345 * 4, 32'h01000480);
    txn(32'h12345678, 1'b0);   // R2, R6 reference set
    txn(32'h12345678, 1'b0);   // R7 no write-back
    txn(32'h12345678, 1'b1);   // R5 write denied
    poke(32'h00300000 + 32'h346 * 4, 32'h02000D80);
    txn(32'h12346ABC, 1'b1);   // R6 dirty set
    txn(32'h12346ABC, 1'b1);   // R7 no change
    poke(32'h00300000 + 32'h347 * 4, 32'h03000C00);
    txn(32'h12347000, 1'b0);   // R4 invalid pte
    txn(32'h7F000000, 1'b0);   // R3 invalid top entry

    // Random tables for two bases
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 4; m++) begin
        logic [19:0] sf;
        sf = 20'h00400 + 20'(b * 16 + m * 4);
        poke(32'h00100000 + 32'(b) * 32'h00080000 + 32'(m) * 4,
             {sf, 4'h0, (($urandom % 4) != 0), 7'h0});
        for (int s = 0; s < 16; s++)
          poke({sf, 12'h0} + 32'(s) * 4,
               {20'($urandom), 4'($urandom), (($urandom % 5) != 0), 7'($urandom)});
      end
    end

    for (int t = 0; t < 300; t++) begin
      if (t == 150) begin
        cur_base = 20'h00180; set_base(cur_base); // R10 new base in use
      end
      txn({8'($urandom % 5), 12'($urandom % 18), 12'($urandom)}, 1'($urandom));
    end

    // R10: same VA under two bases, tables differ in one entry
    poke(32'h00100000 + 32'h20 * 4, 32'h00500080);
    poke(32'h00180000 + 32'h20 * 4, 32'h00000000);
    poke(32'h00500000, 32'h0AAAA580);
    cur_base = 20'h00100; set_base(cur_base);
    txn(32'h20000123, 1'b0);
    cur_base = 20'h00180; set_base(cur_base);
    txn(32'h20000123, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule